// File: doc/BRIEF.md
# Two-of-Three Serial Bit Detector

This block watches a single serial data line, taking one bit on each clock in which the valid strobe is high. Its one-bit flag goes high when exactly two of the three newest accepted bits are 1. The current bit on the input counts as the newest of the three. Three ones in the window, or fewer than two, leave the flag low.

The flag is a Mealy output. It comes from the two stored bits, a fill counter and the live input bit, with no register after the logic. A bit change on the input therefore shows on the flag in the same cycle. The flag stays low until two accepted bits are stored after reset, so the first decision falls on the third accepted bit. A low strobe freezes the stored history and forces the flag low. The window length and the number of ones that counts as a hit are set by elaboration parameters. Their defaults are a window of three and a hit count of two.

Top module: `tot_detector`

## Requirements
- R1: When valid_i is high and at least two bits have been accepted since reset, detect_o is 1 exactly when the two newest stored bits plus data_i hold two ones.
- R2: When the two newest stored bits and data_i are all 1, detect_o is 0.
- R3: When the two newest stored bits and data_i hold fewer than two ones, detect_o is 0.
- R4: While fewer than two bits have been accepted since reset, detect_o is 0, including for the first and second accepted bits.
- R5: When valid_i is low, detect_o is 0 and no bit is accepted. Once the strobe returns, detection continues as if the idle cycles had not happened.
- R6: While rst_ni is low (asynchronous, active low), detect_o is 0, and the history and fill count are cleared.
- R7: detect_o follows a change of data_i within the same clock cycle, with no clock edge between.
- R8: Accepted bits 0,1,1,0,1,1,1,0,0 on consecutive cycles right after reset give detect_o 0,0,1,1,1,1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | High when data_i carries a bit to accept |
| data_i | input | 1 | Serial data bit |
| detect_o | output | 1 | High when exactly two of the three newest bits are 1 |

## Verification
The assertions assume that valid_i and data_i are stable around each rising clock edge and change only between edges. The bench meets this by driving both inputs on the falling edge. The bench then samples the flag one time unit later, and again after a mid-cycle flip of data_i, so the combinational path is checked without racing the edge. The shadow history in the checker assumes reset is released only between clock edges, and the bench releases it on a falling edge.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int unsigned WIN_LEN_DEF  = 3;
  localparam int unsigned HIT_ONES_DEF = 2;
endpackage

// File: rtl/tot_history.sv
module tot_history #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] hist_o
);
  logic [DEPTH-1:0] stage_q;

  // stage_q[0] is the newest stored bit
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = bit_i;
    end else begin : g_tail
      assign d = stage_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[i] <= 1'b0;
      else if (shift_i) stage_q[i] <= d;
    end
  end

  assign hist_o = stage_q;
endmodule

// File: rtl/tot_fill.sv
module tot_fill #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic full_o
);
  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/tot_judge.sv
module tot_judge #(
  parameter int unsigned DEPTH    = 2,
  parameter int unsigned HIT_ONES = 2
) (
  input  logic             valid_i,
  input  logic             full_i,
  input  logic [DEPTH-1:0] hist_i,
  input  logic             bit_i,
  output logic             hit_o
);
  localparam int unsigned SUM_W = $clog2(DEPTH + 2);

  logic [SUM_W-1:0] ones;

  always_comb begin
    ones = SUM_W'(bit_i);
    for (int i = 0; i < DEPTH; i++) ones = ones + SUM_W'(hist_i[i]);
  end

  assign hit_o = valid_i && full_i && (ones == SUM_W'(HIT_ONES));
endmodule

// File: rtl/tot_detector.sv
module tot_detector
  import tot_pkg::*;
#(
  parameter int unsigned WIN_LEN  = WIN_LEN_DEF,
  parameter int unsigned HIT_ONES = HIT_ONES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic data_i,
  output logic detect_o
);
  localparam int unsigned HIST_W = WIN_LEN - 1;

  logic [HIST_W-1:0] hist_q;
  logic              fill_full;

  tot_history #(.DEPTH(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(valid_i),
    .bit_i  (data_i),
    .hist_o (hist_q)
  );

  tot_fill #(.LIMIT(HIST_W)) u_fill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(valid_i),
    .full_o(fill_full)
  );

  tot_judge #(.DEPTH(HIST_W), .HIT_ONES(HIT_ONES)) u_judge (
    .valid_i(valid_i),
    .full_i (fill_full),
    .hist_i (hist_q),
    .bit_i  (data_i),
    .hit_o  (detect_o)
  );
endmodule

// File: rtl/tot_detector_chk.sv
module tot_detector_chk #(
  parameter int unsigned WIN_LEN  = 3,
  parameter int unsigned HIT_ONES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                data_i,
  input logic                detect_o,
  input logic [WIN_LEN-2:0]  hist_q
);
  localparam int unsigned HW = WIN_LEN - 1;

  logic [HW-1:0] shadow_q;
  int unsigned   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      seen_q   <= 0;
    end else if (valid_i) begin
      shadow_q <= (shadow_q << 1) | HW'(data_i);
      if (seen_q < HW) seen_q <= seen_q + 1;
    end
  end

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !detect_o);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_q));

  p_fill_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seen_q < HW) |-> !detect_o);

  p_all_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i && (&shadow_q)) |-> !detect_o);

  p_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seen_q == HW) |->
      (detect_o == ($countones({shadow_q, data_i}) == HIT_ONES)));
endmodule

bind tot_detector tot_detector_chk #(.WIN_LEN(WIN_LEN), .HIT_ONES(HIT_ONES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .detect_o(detect_o),
  .hist_q  (hist_q)
);

// File: tb/tot_detector_tb.sv
module tot_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic data_i = 1'b0;
  logic detect_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_q[$];

  tot_detector u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .detect_o(detect_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: detect_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_out(input logic v, input logic d);
    int ones;
    if (!v || model_q.size() < 2) return 1'b0;
    ones = int'(model_q[0]) + int'(model_q[1]) + int'(d);
    return (ones == 2);
  endfunction

  function automatic string model_tag(input logic v, input logic d);
    int ones;
    if (!v) return "R5";
    if (model_q.size() < 2) return "R4";
    ones = int'(model_q[0]) + int'(model_q[1]) + int'(d);
    if (ones == 3) return "R2";
    if (ones < 2) return "R3";
    return "R1";
  endfunction

  // drive on the falling edge, check 1 time unit later, commit to model
  task automatic step(input logic v, input logic d);
    @(negedge clk_i);
    valid_i = v;
    data_i  = d;
    #1;
    check(model_tag(v, d), detect_o, model_out(v, d));
    if (v) begin
      model_q.push_back(d);
      if (model_q.size() > 2) void'(model_q.pop_front());
    end
  endtask

  initial begin
    logic [8:0] r8_in  = 9'b011011100;
    logic [8:0] r8_exp = 9'b001111010;

    // R6: held in reset
    repeat (3) @(negedge clk_i);
    valid_i = 1'b1; data_i = 1'b1;
    #1 check("R6", detect_o, 1'b0);
    @(negedge clk_i);
    valid_i = 1'b0; rst_ni = 1'b1;

    // R8: example trace, MSB first
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk_i);
      valid_i = 1'b1; data_i = r8_in[i];
      #1 check("R8", detect_o, r8_exp[i]);
      model_q.push_back(r8_in[i]);
      if (model_q.size() > 2) void'(model_q.pop_front());
    end

    // R7: same-cycle response to data_i (history now 0,0 -> push 1,1 first)
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 1'b0;
    #1 check("R7", detect_o, model_out(1'b1, 1'b0));
    #1 data_i = 1'b1;
    #1 check("R7", detect_o, model_out(1'b1, 1'b1));
    model_q.push_back(1'b1);
    if (model_q.size() > 2) void'(model_q.pop_front());

    // R5: idle gap keeps history (stored 0,1)
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);  // 0,1,1 -> R1 hit after gap

    // pseudo-random stream, covers R1 R2 R3 R5
    for (int n = 0; n < 400; n++) begin
      logic v = ($urandom_range(3) != 0);
      logic d = $urandom_range(1);
      step(v, d);
    end

    // R6: asynchronous reset mid-run, then R4 fill window
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 1'b1;
    rst_ni = 1'b0;
    #1 check("R6", detect_o, 1'b0);
    model_q.delete();
    @(negedge clk_i);
    rst_ni = 1'b1; valid_i = 1'b0;
    step(1'b1, 1'b1);   // R4: first bit
    step(1'b1, 1'b1);   // R4: second bit, window 1,1 only
    step(1'b1, 1'b0);   // R1: 1,1,0
    step(1'b1, 1'b1);   // R1: 1,0,1
    step(1'b1, 1'b1);   // R1: 0,1,1
    step(1'b1, 1'b1);   // R2: 1,1,1
    step(1'b1, 1'b0);   // R1
    step(1'b1, 1'b0);   // R3
    step(1'b1, 1'b0);   // R3

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule